// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor on two request lines: a normal line and a fast line. Every source carries a trigger setting (level or edge, with inverted polarity allowed only on the external sources), a 3-bit priority and its own 32-bit handler vector. Software works through a small register port. It can enable and disable sources, clear latched edges, route any source onto the fast line and set a spurious vector. It reads the active vector to acknowledge an interrupt and writes an end-of-interrupt word when the handler is done.

Source 0 is always a fast source. Sources 0, 30 and 31 are external and may select falling-edge or low-level triggering. An acknowledge records the priority of the taken source in an eight-level nesting record. Only a strictly higher priority can raise the normal line again until software signals end-of-interrupt. A protect bit makes vector reads free of side effects. A global mask bit holds both lines low while sources still show as pending.

Top module: `vpic_top`

Register map (byte address on `addr_i`): 0x00+n source n configuration (bits [2:0] priority, bit 3 edge mode, bit 4 inverted polarity); 0x20+n vector of source n; 0x40 enable set mask; 0x41 enable clear mask; 0x42 edge clear mask; 0x43 fast-routing mask; 0x44 active vector (read); 0x45 end-of-interrupt (write); 0x46 spurious vector; 0x47 control (bit 0 protect, bit 1 global mask); 0x48 pending sources (read).

## Requirements
- R1: After reset both request lines and `rdata_o` are 0, all sources are disabled and the spurious vector is 0.
- R2: A level-mode source is pending while its input is high. An external source (0, 30, 31) with bit 4 set is pending while its input is low. Bit 4 has no effect on any other source.
- R3: An edge-mode source latches a rising edge, or a falling edge when it is external with bit 4 set. The latch holds after the input returns and is cleared by writing a 1 in that bit position to address 0x42.
- R4: A read of 0x44 returns the vector of the enabled, pending, non-fast source with the highest priority. Among equal priorities the lowest source number wins. Disabled sources never win.
- R5: A read of 0x44 that returns a source's vector, with protect off, records that priority as in service and clears the source's edge latch. The normal line then stays low for that and lower priorities.
- R6: A source with a priority strictly above the highest one in service raises the normal line again. Each write to 0x45 removes the highest recorded level and restores the previous one.
- R7: With control bit 0 set, reads of 0x44 change neither the service record nor any edge latch.
- R8: A read of 0x44 with no eligible source returns the spurious vector stored at 0x46.
- R9: Source 0 and every source whose bit is set at 0x43 drive only the fast line and never the normal line or the vector read.
- R10: With control bit 1 set, both lines are held low while 0x48 still reports pending sources.
- R11: The normal line rises two clock edges after a level input goes active and three edges after an edge input. Register reads return data after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source inputs, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one edge after the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
An input sampled at one edge shows on `irq_o` or `fiq_o` two edges later for level mode and three edges later for edge mode. Read data appears one edge after the read strobe. An acknowledge or end-of-interrupt changes the normal line one edge after the register access. The bench drives on falling edges and samples on falling edges. It waits at least the stated number of edges before each check, and the latency test samples on the exact falling edge before and after the due edge.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_CFG      = 8'h00;
  localparam logic [ADDR_W-1:0] A_VEC      = 8'h20;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h40;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h41;
  localparam logic [ADDR_W-1:0] A_EDGE_CLR = 8'h42;
  localparam logic [ADDR_W-1:0] A_FAST     = 8'h43;
  localparam logic [ADDR_W-1:0] A_IVR      = 8'h44;
  localparam logic [ADDR_W-1:0] A_EOI      = 8'h45;
  localparam logic [ADDR_W-1:0] A_SPUR     = 8'h46;
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h47;
  localparam logic [ADDR_W-1:0] A_PEND     = 8'h48;
  localparam int CFG_EDGE_BIT = 3;
  localparam int CFG_INV_BIT  = 4;
endpackage

// File: rtl/vpic_src.sv
module vpic_src #(
  parameter bit EXT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic edge_i,
  input  logic inv_i,
  input  logic clr_i,
  output logic pend_o
);
  logic in_q, in_d, latch_q, det;

  assign det    = edge_i & in_q & ~in_d;
  assign pend_o = edge_i ? latch_q : in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= 1'b0;
      in_d    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      in_q    <= raw_i ^ (EXT & inv_i);
      in_d    <= in_q;
      latch_q <= (latch_q & ~clr_i) | det;
    end
  end

  // R3: a clear with no new edge empties the latch
  p_edge_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !det) |=> !latch_q);
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter  int NSRC = 32,
  parameter  int PW   = 3,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]         cand_i,
  input  logic [NSRC-1:0][PW-1:0] prio_i,
  input  logic [PW:0]             thresh_i,
  output logic                    valid_o,
  output logic [IW-1:0]           idx_o,
  output logic [PW-1:0]           prio_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && ({1'b0, prio_i[i]} >= thresh_i) &&
          (!valid_o || prio_i[i] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [PW-1:0] push_lvl_i,
  input  logic          pop_i,
  output logic [PW:0]   thresh_o
);
  localparam int NL = 1 << PW;
  logic [NL-1:0] act_q, act_n;
  logic [PW-1:0] top;
  logic          any;

  always_comb begin
    any = |act_q;
    top = '0;
    for (int i = 0; i < NL; i++)
      if (act_q[i]) top = PW'(i);
    thresh_o = any ? ({1'b0, top} + (PW+1)'(1)) : '0;
    act_n = act_q;
    if (pop_i && any) act_n[top] = 1'b0;
    if (push_i) act_n[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_n;
  end

  // R5: an acknowledge records its level
  p_push_records_r5: assert property (@(posedge clk) disable iff (rst)
    push_i |=> act_q[$past(push_lvl_i)]);
  // R6: end-of-interrupt removes exactly one level
  p_pop_one_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && (act_q != '0)) |=> $countones(act_q) == $countones($past(act_q)) - 1);
endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
  parameter int          NSRC     = 32,
  parameter int          PW       = 3,
  parameter int          DW       = 32,
  parameter logic [31:0] EXT_MASK = 32'hC000_0001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [7:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  import vpic_pkg::*;
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0][PW-1:0] cfg_prio;
  logic [NSRC-1:0]         cfg_edge, cfg_inv, en_q, fast_q, pend, clr, cand, fast_set;
  logic [DW-1:0]           vec_mem [NSRC];
  logic [DW-1:0]           spur_q, vec_q, misc_q;
  logic                    protect_q, gmask_q, sel_vec_q, irq_q, fiq_q;
  logic                    best_valid, ivr_rd, ack, pop, cfg_hit, vec_hit;
  logic [IW-1:0]           best_idx;
  logic [PW-1:0]           best_prio;
  logic [PW:0]             thresh;

  assign cfg_hit  = wr_en_i && (addr_i >= A_CFG) && (addr_i < A_CFG + 8'(NSRC));
  assign vec_hit  = wr_en_i && (addr_i >= A_VEC) && (addr_i < A_VEC + 8'(NSRC));
  assign ivr_rd   = rd_en_i && (addr_i == A_IVR);
  assign pop      = wr_en_i && (addr_i == A_EOI);
  assign ack      = ivr_rd && best_valid && !protect_q;
  assign fast_set = fast_q | NSRC'(1);
  assign cand     = pend & en_q & ~fast_set;

  always_comb begin
    clr = '0;
    if (wr_en_i && addr_i == A_EDGE_CLR) clr = wdata_i[NSRC-1:0];
    if (ack) clr[best_idx] = 1'b1;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vpic_src #(.EXT(EXT_MASK[g])) i_src (
      .clk(clk), .rst(rst), .raw_i(src_i[g]), .edge_i(cfg_edge[g]),
      .inv_i(cfg_inv[g]), .clr_i(clr[g]), .pend_o(pend[g]));
  end

  vpic_arb #(.NSRC(NSRC), .PW(PW)) i_arb (
    .cand_i(cand), .prio_i(cfg_prio), .thresh_i(thresh),
    .valid_o(best_valid), .idx_o(best_idx), .prio_o(best_prio));

  vpic_stack #(.PW(PW)) i_stack (
    .clk(clk), .rst(rst), .push_i(ack), .push_lvl_i(best_prio),
    .pop_i(pop), .thresh_o(thresh));

  // Control and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_prio  <= '0;
      cfg_edge  <= '0;
      cfg_inv   <= '0;
      en_q      <= '0;
      fast_q    <= '0;
      spur_q    <= '0;
      protect_q <= 1'b0;
      gmask_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (cfg_hit) begin
        cfg_prio[addr_i[IW-1:0]] <= wdata_i[PW-1:0];
        cfg_edge[addr_i[IW-1:0]] <= wdata_i[CFG_EDGE_BIT];
        cfg_inv[addr_i[IW-1:0]]  <= wdata_i[CFG_INV_BIT];
      end
      case (addr_i)
        A_EN_SET: en_q   <= en_q | wdata_i[NSRC-1:0];
        A_EN_CLR: en_q   <= en_q & ~wdata_i[NSRC-1:0];
        A_FAST:   fast_q <= wdata_i[NSRC-1:0];
        A_SPUR:   spur_q <= wdata_i;
        A_CTRL: begin
          protect_q <= wdata_i[0];
          gmask_q   <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  // Vector storage: no reset, synchronous read
  always_ff @(posedge clk) begin
    if (vec_hit) vec_mem[addr_i[IW-1:0]] <= wdata_i;
    vec_q <= vec_mem[best_idx];
  end

  // Read path and request lines
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vec_q <= 1'b0;
      misc_q    <= '0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
    end else begin
      irq_q <= !gmask_q && best_valid;
      fiq_q <= !gmask_q && |(pend & en_q & fast_set);
      if (rd_en_i) begin
        sel_vec_q <= ivr_rd && best_valid;
        case (addr_i)
          A_IVR:   misc_q <= spur_q;
          A_PEND:  misc_q <= DW'(pend);
          A_CTRL:  misc_q <= DW'({gmask_q, protect_q});
          default: misc_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = sel_vec_q ? vec_q : misc_q;
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;

  // R10: global mask silences both lines
  p_gmask_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    gmask_q |=> (!irq_o && !fiq_o));
  // R7: protected reads leave the service record alone
  p_protect_noside_r7: assert property (@(posedge clk) disable iff (rst)
    (ivr_rd && protect_q && !pop) |=> $stable(thresh));
  // R8: nothing eligible returns the spurious vector
  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (ivr_rd && !best_valid) |=> rdata_o == $past(spur_q));
endmodule

// File: tb/test_vpic_top.sv
`timescale 1ns/1ps
module test_vpic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;
  int          n_run = 0, n_fail = 0;
  logic [31:0] rv;

  localparam logic [31:0] SPUR = 32'hDEAD_0000;
  // {enable mask, source levels, expected vector}; priority of source n is n%8
  localparam logic [95:0] TBL [7] = '{
    {32'hFFFF_FFFF, 32'h0000_0028, 32'h0000_0105},
    {32'hFFFF_FFFF, 32'h0000_2020, 32'h0000_0105},
    {32'hFFFF_FFFF, 32'h0000_0280, 32'h0000_0107},
    {32'hFFFF_FFFF, 32'h0002_0200, 32'h0000_0109},
    {32'hFFFF_7FFF, 32'h0080_8000, 32'h0000_0117},
    {32'hFFFF_FFFF, 32'h0000_0000, SPUR},
    {32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0101}};

  always #2.5 clk = ~clk;

  vpic_top i_vpic_top (.clk(clk), .rst(rst), .src_i(src_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_reset();
    src_i = '0;
    @(negedge clk); rst = 1'b1;
    wait_n(3); rst = 1'b0;
  endtask

  task automatic setup();
    for (int i = 0; i < 32; i++) begin
      wr(8'(i), 32'(i % 8));
      wr(8'h20 + 8'(i), 32'h100 + 32'(i));
    end
    wr(8'h46, SPUR);
    wr(8'h40, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 irq after reset", 32'(irq_o), 0);
    check("R1 fiq after reset", 32'(fiq_o), 0);
    check("R1 rdata after reset", rdata_o, 0);
    rd(8'h44, rv); check("R1 R8 spurious after reset", rv, 0);

    // Vector table walk, protect on (R4, R8)
    setup();
    wr(8'h47, 32'h1);
    for (int k = 0; k < 7; k++) begin
      wr(8'h41, 32'hFFFF_FFFF);
      wr(8'h40, TBL[k][95:64]);
      src_i = TBL[k][63:32];
      wait_n(3);
      check("R4 irq level in table", 32'(irq_o), 32'(TBL[k][31:0] != SPUR));
      rd(8'h44, rv);
      check("R4 R8 vector in table", rv, TBL[k][31:0]);
      src_i = '0;
      wait_n(3);
    end

    // R11 latency, level then edge
    do_reset(); setup();
    @(negedge clk); src_i = 32'h20;
    @(negedge clk); check("R11 level one edge", 32'(irq_o), 0);
    @(negedge clk); check("R11 level two edges", 32'(irq_o), 1);
    src_i = 0; wait_n(3);
    wr(8'd6, 32'h0E);
    @(negedge clk); src_i = 32'h40;
    wait_n(2); check("R11 edge two edges", 32'(irq_o), 0);
    @(negedge clk); check("R11 edge three edges", 32'(irq_o), 1);

    // R2 level polarity
    do_reset(); setup();
    wr(8'd4, 32'h14);
    wait_n(3); rd(8'h48, rv); check("R2 internal inv ignored low", rv, 0);
    src_i = 32'h10; wait_n(3); rd(8'h48, rv); check("R2 internal inv ignored high", rv, 32'h10);
    src_i = 0;
    wr(8'd30, 32'h16);
    wait_n(3); rd(8'h48, rv); check("R2 external low level", rv, 32'h4000_0000);

    // R3 edge latching
    do_reset(); setup();
    wr(8'd6, 32'h0E);
    @(negedge clk); src_i = 32'h40; @(negedge clk); src_i = 0;
    wait_n(3); rd(8'h48, rv); check("R3 rising latched", rv, 32'h40);
    wr(8'h42, 32'h40);
    rd(8'h48, rv); check("R3 edge clear", rv, 0);
    src_i = 32'h8000_0000; wait_n(2);
    wr(8'd31, 32'h1F);
    wait_n(3); rd(8'h48, rv); check("R3 rising ignored on falling source", rv, 0);
    src_i = 0; wait_n(3); rd(8'h48, rv); check("R3 falling latched", rv, 32'h8000_0000);

    // R5 acknowledge clears edge latch
    do_reset(); setup();
    wr(8'd6, 32'h0E);
    @(negedge clk); src_i = 32'h40; @(negedge clk); src_i = 0;
    wait_n(3); rd(8'h44, rv); check("R5 edge vector", rv, 32'h106);
    rd(8'h48, rv); check("R5 ack clears latch", rv, 0);

    // R5 R6 nesting, then R7 protect
    do_reset(); setup();
    src_i = 32'h4; wait_n(3);
    check("R4 irq low priority", 32'(irq_o), 1);
    rd(8'h44, rv); check("R5 vector src2", rv, 32'h102);
    wait_n(2); check("R5 irq held after ack", 32'(irq_o), 0);
    src_i = 32'h44; wait_n(3);
    check("R6 preempt raises irq", 32'(irq_o), 1);
    rd(8'h44, rv); check("R6 vector src6", rv, 32'h106);
    wait_n(2); check("R6 irq low in nested", 32'(irq_o), 0);
    src_i = 32'h4; wait_n(3);
    wr(8'h45, 0); wait_n(2); check("R6 first pop keeps level 2", 32'(irq_o), 0);
    wr(8'h45, 0); wait_n(2); check("R6 second pop restores", 32'(irq_o), 1);
    wr(8'h47, 32'h1);
    rd(8'h44, rv); check("R7 protected read 1", rv, 32'h102);
    rd(8'h44, rv); check("R7 protected read 2", rv, 32'h102);
    wait_n(2); check("R7 irq stays", 32'(irq_o), 1);

    // R9 fast routing
    do_reset(); setup();
    src_i = 32'h1; wait_n(3);
    check("R9 source0 fiq", 32'(fiq_o), 1);
    check("R9 source0 not irq", 32'(irq_o), 0);
    src_i = 0;
    wr(8'h43, 32'h8);
    src_i = 32'h8; wait_n(3);
    check("R9 forced fiq", 32'(fiq_o), 1);
    check("R9 forced not irq", 32'(irq_o), 0);
    rd(8'h44, rv); check("R9 forced gives spurious", rv, SPUR);

    // R10 global mask
    do_reset(); setup();
    wr(8'h47, 32'h2);
    src_i = 32'h21; wait_n(3);
    check("R10 irq masked", 32'(irq_o), 0);
    check("R10 fiq masked", 32'(fiq_o), 0);
    rd(8'h48, rv); check("R10 pending visible", rv, 32'h21);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule